// File: doc/BRIEF.md
# Three-stage pipeline hazard controller

This unit supervises operand hazards and control-flow redirection for a three-stage, in-order, single-issue integer pipeline. The first stage only fetches. The second stage decodes and reads the register file. The third stage performs the ALU operation, the data-memory access and branch resolution. The unit tracks which of the two later stages hold a live instruction. Each cycle it compares the two source indices of the stage-2 instruction against the destination held in stage 3 and drives one bypass select per operand.

There is no delay slot. When stage 3 resolves a taken branch or jump, the unit raises a kill and points the next fetch at the target. It then retires both younger instructions, the one in stage 2 and the one being fetched, as bubbles. The stage-3 side effects are the register write, the data-memory request and the host-register write. The unit gates them with stage validity, so that a squashed instruction changes no architectural state. Register read sits one stage ahead of execute, so a single bypass path from stage 3 covers every back-to-back dependence and nothing ever stalls.

All pins are plain control levels. The memories answer within the cycle, so no handshake or back-pressure exists at this boundary. The fetch enable input is the only way to hold the pipeline front.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: While reset (rst_n low, asynchronous) is asserted, and after its release, both stage-valid outputs are 0, fetch_pc is 0, and kill, rf_we, dmem_val and host_we are 0, whatever ex_taken is.
- R2: byp_rs1 is 1 (take the stage-3 result) exactly when stage 3 is valid, its instruction writes a register, its destination is nonzero and equals id_rs1. Otherwise byp_rs1 is 0 (take the register file).
- R3: byp_rs2 follows the same rule against id_rs2, independently of byp_rs1. Both may be 1 in the same cycle.
- R4: A destination index of 0 never produces a bypass, even when the source index is also 0.
- R5: No bypass is selected when stage 3 is empty or its instruction does not write a register, even when the indices match.
- R6: When stage 3 is valid and ex_taken is 1, kill and pc_sel are both 1 in that cycle. On the next edge, fetch_pc loads ex_target and both stage-valid outputs go to 0.
- R7: An instruction squashed by R6 never asserts rf_we, dmem_val or host_we, and never becomes a bypass source.
- R8: ex_taken is ignored while stage 3 is empty. Without a redirect, fetch_pc advances by 4 on each edge where fetch_en is 1.
- R9: With fetch_en at 0 and no redirect, fetch_pc holds, and a bubble (stage-2 valid 0) enters the pipeline on the next edge.
- R10: The id_wen, id_dmem and id_host flags of a valid stage-2 instruction appear on rf_we, dmem_val and host_we in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_en | input | 1 | Fetch a new instruction this cycle |
| id_rs1 | input | 5 | Stage-2 first source index |
| id_rs2 | input | 5 | Stage-2 second source index |
| id_rd | input | 5 | Stage-2 destination index |
| id_wen | input | 1 | Stage-2 instruction writes a register |
| id_dmem | input | 1 | Stage-2 instruction accesses data memory |
| id_host | input | 1 | Stage-2 instruction writes the host register |
| ex_taken | input | 1 | Stage-3 branch/jump outcome is taken |
| ex_target | input | 32 | Stage-3 branch/jump target address |
| fetch_pc | output | 32 | Address being fetched this cycle |
| pc_sel | output | 1 | Next-PC select: 0 sequential, 1 target |
| kill | output | 1 | Squash the stage-1 and stage-2 instructions |
| s2_valid | output | 1 | Stage 2 holds a live instruction |
| s3_valid | output | 1 | Stage 3 holds a live instruction |
| byp_rs1 | output | 1 | Operand 1 select: 0 register file, 1 stage-3 result |
| byp_rs2 | output | 1 | Operand 2 select: 0 register file, 1 stage-3 result |
| rf_we | output | 1 | Stage-3 register write enable |
| dmem_val | output | 1 | Stage-3 data-memory request valid |
| host_we | output | 1 | Stage-3 host-register write |

## Verification
The hardest case to reach is a squashed instruction whose fields would cause damage if it survived. The stimulus places a register-writing, memory-accessing, host-writing instruction in stage 2 during the cycle of a taken branch. In the cycle after, it places a reader of that same register. ex_taken is held high through the bubbles that follow. This shows that the stale stage-3 fields neither forward nor raise any side effect, and that the stale outcome does not redirect a second time.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic {BYP_RF = 1'b0, BYP_EX = 1'b1} byp_sel_e;
  typedef enum logic {PC_SEQ = 1'b0, PC_TGT = 1'b1} pc_sel_e;

  typedef struct packed {
    logic wen;
    logic dmem;
    logic host;
  } fx_t;
endpackage

// File: rtl/hzd_stage_track.sv
module hzd_stage_track
  import hzd_pkg::*;
#(
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_en,
  input  logic              kill,
  input  logic [RIDX_W-1:0] id_rd,
  input  fx_t               id_fx,
  output logic              s2_vld,
  output logic              s3_vld,
  output logic [RIDX_W-1:0] s3_rd,
  output fx_t               s3_fx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld <= 1'b0;
      s3_vld <= 1'b0;
      s3_rd  <= '0;
      s3_fx  <= '0;
    end else begin
      s2_vld <= fetch_en & ~kill;
      s3_vld <= s2_vld & ~kill;
      s3_rd  <= id_rd;
      s3_fx  <= id_fx;
    end
  end

  // R6
  squash_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!s2_vld && !s3_vld));

  // R9
  bubble_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_en |=> !s2_vld);
endmodule

// File: rtl/hzd_fwd_cmp.sv
module hzd_fwd_cmp
  import hzd_pkg::*;
#(
  parameter int RIDX_W = 5
) (
  input  logic              s3_vld,
  input  logic              s3_wen,
  input  logic [RIDX_W-1:0] s3_rd,
  input  logic [RIDX_W-1:0] src,
  output byp_sel_e          sel
);
  logic hit;

  always_comb begin
    hit = s3_vld && s3_wen && (s3_rd != '0) && (s3_rd == src);
    sel = hit ? BYP_EX : BYP_RF;
  end

  always_comb begin
    // R4
    zero_dest_chk: assert (!((s3_rd == '0) && (sel == BYP_EX)));
    // R5
    idle_src_chk: assert (!((!s3_vld || !s3_wen) && (sel == BYP_EX)));
  end
endmodule

// File: rtl/hzd_redirect.sv
module hzd_redirect
  import hzd_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int ISZ_B = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_en,
  input  logic            s3_vld,
  input  logic            ex_taken,
  input  logic [XLEN-1:0] ex_target,
  output logic            kill,
  output pc_sel_e         pc_sel,
  output logic [XLEN-1:0] fetch_pc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(ISZ_B);

  logic [XLEN-1:0] pc_nxt;

  always_comb begin
    kill   = s3_vld & ex_taken;
    pc_sel = kill ? PC_TGT : PC_SEQ;
    pc_nxt = (pc_sel == PC_TGT) ? ex_target : (fetch_pc + STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              fetch_pc <= '0;
    else if (kill | fetch_en) fetch_pc <= pc_nxt;
  end

  // R6
  target_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (fetch_pc == $past(ex_target)));

  // R9
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill && !fetch_en) |=> $stable(fetch_pc));
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hzd_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_en,
  input  logic [RIDX_W-1:0] id_rs1,
  input  logic [RIDX_W-1:0] id_rs2,
  input  logic [RIDX_W-1:0] id_rd,
  input  logic              id_wen,
  input  logic              id_dmem,
  input  logic              id_host,
  input  logic              ex_taken,
  input  logic [XLEN-1:0]   ex_target,
  output logic [XLEN-1:0]   fetch_pc,
  output logic              pc_sel,
  output logic              kill,
  output logic              s2_valid,
  output logic              s3_valid,
  output logic              byp_rs1,
  output logic              byp_rs2,
  output logic              rf_we,
  output logic              dmem_val,
  output logic              host_we
);
  localparam int NSRC = 2;

  fx_t               id_fx, s3_fx;
  logic [RIDX_W-1:0] s3_rd;
  logic [RIDX_W-1:0] srcs [NSRC];
  byp_sel_e          sels [NSRC];
  pc_sel_e           psel;

  assign id_fx   = '{wen: id_wen, dmem: id_dmem, host: id_host};
  assign srcs[0] = id_rs1;
  assign srcs[1] = id_rs2;

  hzd_stage_track #(.RIDX_W(RIDX_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .fetch_en (fetch_en),
    .kill     (kill),
    .id_rd    (id_rd),
    .id_fx    (id_fx),
    .s2_vld   (s2_valid),
    .s3_vld   (s3_valid),
    .s3_rd    (s3_rd),
    .s3_fx    (s3_fx)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hzd_fwd_cmp #(.RIDX_W(RIDX_W)) u_cmp (
      .s3_vld (s3_valid),
      .s3_wen (s3_fx.wen),
      .s3_rd  (s3_rd),
      .src    (srcs[g]),
      .sel    (sels[g])
    );
  end

  hzd_redirect #(.XLEN(XLEN)) u_redir (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_en  (fetch_en),
    .s3_vld    (s3_valid),
    .ex_taken  (ex_taken),
    .ex_target (ex_target),
    .kill      (kill),
    .pc_sel    (psel),
    .fetch_pc  (fetch_pc)
  );

  always_comb begin
    pc_sel   = (psel == PC_TGT);
    byp_rs1  = (sels[0] == BYP_EX);
    byp_rs2  = (sels[1] == BYP_EX);
    rf_we    = s3_valid & s3_fx.wen;
    dmem_val = s3_valid & s3_fx.dmem;
    host_we  = s3_valid & s3_fx.host;
  end

  // R7
  squashed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!rf_we && !dmem_val && !host_we && !byp_rs1 && !byp_rs2));

  // R10
  fx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && !kill) |=> (rf_we == $past(id_wen) && dmem_val == $past(id_dmem)
                             && host_we == $past(id_host)));
endmodule

// File: tb/pipe_hazard_ctrl_test.sv
module pipe_hazard_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_en = 1'b0;
  logic [4:0]  id_rs1 = '0, id_rs2 = '0, id_rd = '0;
  logic        id_wen = 1'b0, id_dmem = 1'b0, id_host = 1'b0, ex_taken = 1'b0;
  logic [31:0] ex_target = 32'h0000_0100;
  logic [31:0] fetch_pc;
  logic        pc_sel, kill, s2_valid, s3_valid, byp_rs1, byp_rs2;
  logic        rf_we, dmem_val, host_we;
  int          total = 0, bad = 0;

  always #5 clk = ~clk;

  pipe_hazard_ctrl uut (
    .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en),
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rd(id_rd),
    .id_wen(id_wen), .id_dmem(id_dmem), .id_host(id_host),
    .ex_taken(ex_taken), .ex_target(ex_target),
    .fetch_pc(fetch_pc), .pc_sel(pc_sel), .kill(kill),
    .s2_valid(s2_valid), .s3_valid(s3_valid),
    .byp_rs1(byp_rs1), .byp_rs2(byp_rs2),
    .rf_we(rf_we), .dmem_val(dmem_val), .host_we(host_we)
  );

  // {fetch_en, rs1, rs2, rd, {wen,dmem,host,taken},
  //  {byp1,byp2,kill,pcsel,s2v,s3v,rfwe,dmemv,hostwe}, pc[11:0]}
  localparam int NV = 16;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 5'd0, 5'd0, 5'd0, 4'b0000, 9'b000000000, 12'h000}, // R8 first fetch
    {1'b1, 5'd0, 5'd0, 5'd1, 4'b1000, 9'b000010000, 12'h004}, // R5 stage 3 empty
    {1'b1, 5'd1, 5'd2, 5'd2, 4'b1000, 9'b100011100, 12'h008}, // R2 rs1 dep
    {1'b1, 5'd3, 5'd2, 5'd3, 4'b1000, 9'b010011100, 12'h00c}, // R3 rs2 dep
    {1'b1, 5'd3, 5'd3, 5'd0, 4'b1000, 9'b110011100, 12'h010}, // R2 R3 both
    {1'b1, 5'd0, 5'd0, 5'd5, 4'b1000, 9'b000011100, 12'h014}, // R4 x0 match
    {1'b1, 5'd5, 5'd5, 5'd5, 4'b0100, 9'b110011100, 12'h018}, // R10 store in s2
    {1'b1, 5'd5, 5'd0, 5'd0, 4'b0000, 9'b000011010, 12'h01c}, // R5 non-writer
    {1'b1, 5'd0, 5'd0, 5'd6, 4'b1111, 9'b001111000, 12'h020}, // R6 taken
    {1'b1, 5'd6, 5'd6, 5'd6, 4'b1111, 9'b000000000, 12'h100}, // R8 stale taken
    {1'b1, 5'd6, 5'd6, 5'd0, 4'b0011, 9'b000010000, 12'h104}, // R7 squashed quiet
    {1'b1, 5'd0, 5'd0, 5'd0, 4'b0000, 9'b000011001, 12'h108}, // R10 host write
    {1'b1, 5'd0, 5'd0, 5'd7, 4'b1000, 9'b000011000, 12'h10c}, // R8 not-taken
    {1'b0, 5'd7, 5'd0, 5'd0, 4'b0000, 9'b100011100, 12'h110}, // R9 idle fetch
    {1'b1, 5'd0, 5'd0, 5'd0, 4'b0000, 9'b000001000, 12'h110}, // R9 bubble
    {1'b1, 5'd0, 5'd0, 5'd0, 4'b0000, 9'b000010000, 12'h114}  // R9 resumes
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #4;
    chk("R1 reset valids", {30'd0, s2_valid, s3_valid}, 32'd0);
    chk("R1 reset pc", fetch_pc, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [40:0] v;
      v = VEC[i];
      {fetch_en, id_rs1, id_rs2, id_rd} = v[40:25];
      {id_wen, id_dmem, id_host, ex_taken} = v[24:21];
      #4;
      chk("R2/R4/R5 byp_rs1", 32'(byp_rs1), 32'(v[20]));
      chk("R3/R4/R5 byp_rs2", 32'(byp_rs2), 32'(v[19]));
      chk("R6/R8 kill,pc_sel", {30'd0, kill, pc_sel}, {30'd0, v[18:17]});
      chk("R1/R9 valids", {30'd0, s2_valid, s3_valid}, {30'd0, v[16:15]});
      chk("R7/R10 side effects", {29'd0, rf_we, dmem_val, host_we}, {29'd0, v[14:12]});
      chk("R6/R8/R9 fetch_pc", fetch_pc, {20'd0, v[11:0]});
      @(negedge clk);
    end
    // R1 directed: reset asserted with a live pipeline and a taken outcome
    fetch_en = 1'b1; id_wen = 1'b1; id_dmem = 1'b1; id_host = 1'b1; ex_taken = 1'b0;
    repeat (2) @(negedge clk);
    ex_taken = 1'b1;
    rst_n = 1'b0;
    #4;
    chk("R1 mid-run reset valids", {30'd0, s2_valid, s3_valid}, 32'd0);
    chk("R1 mid-run reset pc", fetch_pc, 32'd0);
    chk("R1 mid-run reset quiet", {28'd0, kill, rf_we, dmem_val, host_we}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #4;
    chk("R1 after release", {29'd0, kill, s2_valid, s3_valid}, 32'd0);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule